// File: doc/BRIEF.md
# Serial Audio DAC Input Register

This block takes audio samples from a three-wire serial port: a bit clock, a data line and an active-low latch enable. It turns them into a parallel word for a downstream DAC model. Each sample is a two's complement word of `WORD_W` bits, 16 or 18, sent most significant bit first. One bit is taken on every rising bit-clock edge. Bits collect in a shift register. A low-going latch-enable pulse copies the shift register into a parallel holding register. Only that register drives the outputs. The block also presents an offset-binary copy of the held word for DAC models that expect unsigned codes.

All three pins are asynchronous to the system clock `clk`, which runs much faster than the bit clock. Each pin passes through a synchronizer of `SYNC_STAGES` flops. Edges are then found by comparing each synchronized level with its value one cycle earlier. The block measures, in system-clock cycles, the following intervals:

- data setup before each rising bit-clock edge;
- data hold after each rising bit-clock edge;
- bit-clock high time, low time and period;
- latch-enable low time.

Any measured interval shorter than its parameterized minimum raises a sticky violation flag. The output stream is push-only: `word_vld_o` pulses for one cycle whenever a new word is held. The serial source cannot be stalled, so the block has no ready input and applies no back-pressure. A consumer must take the word in the cycle `word_vld_o` is high, or read it later from `word_o`, which stays steady until the next latch.

Top module: `sdac_input_reg`

## Requirements
- R1: While `rst_n` is low, the held word is cleared to the two's complement midscale code 0, `word_ob_o` reads only bit `WORD_W-1` set (0x8000 for 16 bits), `word_vld_o` is low and all three violation flags are clear.
- R2: On each rising edge of the synchronized bit clock, the synchronized data level is shifted into the shift register at bit 0, and earlier bits move toward the MSB. After `WORD_W` rising edges and a latch, the first bit sent is bit `WORD_W-1` of `word_o`.
- R3: `word_o` changes only on a falling edge of the synchronized latch enable. Any number of bit-clock edges without such an edge leaves `word_o` unchanged.
- R4: If more than `WORD_W` bits are clocked in before a latch, only the most recent `WORD_W` bits are held.
- R5: `word_ob_o` equals `word_o` with bit `WORD_W-1` inverted and all other bits unchanged.
- R6: `word_vld_o` is high for exactly one cycle per latch-enable falling edge, in the same cycle the new word first appears on `word_o`.
- R7: `err_setup_o` rises when the synchronized data line changed fewer than `SETUP_MIN` cycles before a rising bit-clock edge. A change in the same cycle as the edge counts as zero cycles.
- R8: `err_hold_o` rises when the synchronized data line changes 1 to `HOLD_MIN-1` cycles after a rising bit-clock edge.
- R9: `err_width_o` rises when any of these is true:
  - the bit clock stays high fewer than `CLK_HI_MIN` cycles;
  - the bit clock stays low fewer than `CLK_LO_MIN` cycles;
  - two rising bit-clock edges are fewer than `PERIOD_MIN` cycles apart;
  - latch enable stays low fewer than `LATCH_LO_MIN` cycles.
- R10: Once raised, each violation flag stays high until reset. Later clean traffic does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| sdata_i | input | 1 | Serial data, MSB first, two's complement |
| lat_n_i | input | 1 | Active-low latch enable; its falling edge loads the held word |
| word_o | output | WORD_W | Held sample, two's complement |
| word_ob_o | output | WORD_W | Held sample, offset binary |
| word_vld_o | output | 1 | One-cycle strobe marking a newly held word |
| err_setup_o | output | 1 | Sticky data-setup violation flag |
| err_hold_o | output | 1 | Sticky data-hold violation flag |
| err_width_o | output | 1 | Sticky clock or latch pulse-width violation flag |

## Verification
The assertions check the following on every cycle:

- the reset state (R1);
- that the held word never changes without a valid strobe (R3);
- that the strobe never lasts two cycles (R6);
- that no violation flag ever falls outside reset (R10).

The serial ordering, the keeping of only the last bits, the offset-binary mapping and the exact thresholds of each timing check depend on the pin waveforms. Only the bench's scenarios show these. The bench uses a vector table for the word path and targeted waveforms that break a single timing rule at a time.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // bit positions of the three serial pins inside the synchronizer vector
  localparam int PIN_BCLK = 0;
  localparam int PIN_DATA = 1;
  localparam int PIN_LAT  = 2;
  localparam int NPINS    = 3;

  typedef struct packed {
    logic setup;
    logic hold;
    logic width;
  } viol_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int NPINS = 3,
  parameter int STAGES = 2,
  parameter logic [NPINS-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] prv_o
);
  logic [NPINS-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= RST_VAL;
      else if (s == 0) stage[s] <= pin_i;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_o <= RST_VAL;
    else prv_o <= stage[STAGES-1];
  end

  assign lvl_o = stage[STAGES-1];
endmodule

// File: rtl/sdac_timing_mon.sv
module sdac_timing_mon
  import sdac_pkg::*;
#(
  parameter int SETUP_MIN    = 6,
  parameter int HOLD_MIN     = 3,
  parameter int CLK_HI_MIN   = 6,
  parameter int CLK_LO_MIN   = 6,
  parameter int PERIOD_MIN   = 16,
  parameter int LATCH_LO_MIN = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bclk_rise,
  input  logic  bclk_fall,
  input  logic  data_chg,
  input  logic  lat_fall,
  input  logic  lat_rise,
  output viol_t viol_o
);
  localparam int LIM = imax(imax(imax(SETUP_MIN, HOLD_MIN), imax(CLK_HI_MIN, CLK_LO_MIN)),
                            imax(PERIOD_MIN, LATCH_LO_MIN));
  localparam int CNT_W = $clog2(LIM + 1) + 1;
  localparam logic [CNT_W-1:0] SAT     = '1;
  localparam logic [CNT_W-1:0] SETUP_L = CNT_W'(SETUP_MIN);
  localparam logic [CNT_W-1:0] HOLD_L  = CNT_W'(HOLD_MIN);
  localparam logic [CNT_W-1:0] HI_L    = CNT_W'(CLK_HI_MIN);
  localparam logic [CNT_W-1:0] LO_L    = CNT_W'(CLK_LO_MIN);
  localparam logic [CNT_W-1:0] PER_L   = CNT_W'(PERIOD_MIN);
  localparam logic [CNT_W-1:0] LAT_L   = CNT_W'(LATCH_LO_MIN);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  // cycles elapsed since the last data change, clock rise, clock fall, latch fall
  logic [CNT_W-1:0] age_data, since_rise, since_fall, lat_low;
  logic [CNT_W-1:0] age_eff;
  logic setup_bad, hold_bad, width_bad;

  function automatic logic [CNT_W-1:0] step(input logic restart, input logic [CNT_W-1:0] c);
    if (restart) return ONE;
    if (c != SAT) return c + ONE;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_data   <= SAT;
      since_rise <= SAT;
      since_fall <= SAT;
      lat_low    <= SAT;
    end else begin
      age_data   <= step(data_chg, age_data);
      since_rise <= step(bclk_rise, since_rise);
      since_fall <= step(bclk_fall, since_fall);
      lat_low    <= step(lat_fall, lat_low);
    end
  end

  assign age_eff   = data_chg ? '0 : age_data;
  assign setup_bad = bclk_rise && (age_eff < SETUP_L);
  assign hold_bad  = data_chg && !bclk_rise && (since_rise < HOLD_L);
  assign width_bad = (bclk_fall && (since_rise < HI_L)) ||
                     (bclk_rise && (since_fall < LO_L)) ||
                     (bclk_rise && (since_rise < PER_L)) ||
                     (lat_rise  && (lat_low < LAT_L));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_o <= '0;
    else begin
      viol_o.setup <= viol_o.setup | setup_bad;
      viol_o.hold  <= viol_o.hold  | hold_bad;
      viol_o.width <= viol_o.width | width_bad;
    end
  end
endmodule

// File: rtl/sdac_shift_latch.sv
module sdac_shift_latch #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  input  logic              load_en,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (shift_en) shreg <= {shreg[WORD_W-2:0], bit_i};
  end

  // a load in the same cycle as a shift takes the word before that shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= load_en;
      if (load_en) word_o <= shreg;
    end
  end
endmodule

// File: rtl/sdac_input_reg.sv
module sdac_input_reg
  import sdac_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int SETUP_MIN    = 6,
  parameter int HOLD_MIN     = 3,
  parameter int CLK_HI_MIN   = 6,
  parameter int CLK_LO_MIN   = 6,
  parameter int PERIOD_MIN   = 16,
  parameter int LATCH_LO_MIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              sdata_i,
  input  logic              lat_n_i,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] word_ob_o,
  output logic              word_vld_o,
  output logic              err_setup_o,
  output logic              err_hold_o,
  output logic              err_width_o
);
  localparam logic [NPINS-1:0] IDLE = NPINS'(1) << PIN_LAT;

  logic [NPINS-1:0] pins, lvl, prv, rise, fall;
  viol_t viol;

  always_comb begin
    pins           = '0;
    pins[PIN_BCLK] = bclk_i;
    pins[PIN_DATA] = sdata_i;
    pins[PIN_LAT]  = lat_n_i;
  end

  sdac_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .lvl_o(lvl), .prv_o(prv)
  );

  assign rise = lvl & ~prv;
  assign fall = ~lvl & prv;

  sdac_shift_latch #(.WORD_W(WORD_W)) u_path (
    .clk(clk), .rst_n(rst_n),
    .shift_en(rise[PIN_BCLK]), .bit_i(lvl[PIN_DATA]),
    .load_en(fall[PIN_LAT]),
    .word_o(word_o), .vld_o(word_vld_o)
  );

  sdac_timing_mon #(
    .SETUP_MIN(SETUP_MIN), .HOLD_MIN(HOLD_MIN), .CLK_HI_MIN(CLK_HI_MIN),
    .CLK_LO_MIN(CLK_LO_MIN), .PERIOD_MIN(PERIOD_MIN), .LATCH_LO_MIN(LATCH_LO_MIN)
  ) u_mon (
    .clk(clk), .rst_n(rst_n),
    .bclk_rise(rise[PIN_BCLK]), .bclk_fall(fall[PIN_BCLK]),
    .data_chg(rise[PIN_DATA] | fall[PIN_DATA]),
    .lat_fall(fall[PIN_LAT]), .lat_rise(rise[PIN_LAT]),
    .viol_o(viol)
  );

  assign word_ob_o   = word_o ^ (WORD_W'(1) << (WORD_W - 1));
  assign err_setup_o = viol.setup;
  assign err_hold_o  = viol.hold;
  assign err_width_o = viol.width;
endmodule

// File: rtl/sdac_input_reg_chk.sv
module sdac_input_reg_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] word,
  input logic         vld,
  input logic         e_setup,
  input logic         e_hold,
  input logic         e_width
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (word == '0 && !vld && !e_setup && !e_hold && !e_width));

  a_r3_word_moves_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word) |-> vld);

  a_r6_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  a_r10_setup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(e_setup) |-> e_setup);

  a_r10_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(e_hold) |-> e_hold);

  a_r10_width_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(e_width) |-> e_width);
endmodule

bind sdac_input_reg sdac_input_reg_chk #(.W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word(word_o), .vld(word_vld_o),
  .e_setup(err_setup_o), .e_hold(err_hold_o), .e_width(err_width_o)
);

// File: tb/sdac_input_reg_bench.sv
module sdac_input_reg_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, sdata = 1'b0, lat_n = 1'b1;
  logic [W-1:0] word, word_ob;
  logic vld, e_setup, e_hold, e_width;

  int checks = 0;
  int failures = 0;
  int vld_count = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdac_input_reg #(.WORD_W(W)) u_sdac_input_reg (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .sdata_i(sdata), .lat_n_i(lat_n),
    .word_o(word), .word_ob_o(word_ob), .word_vld_o(vld),
    .err_setup_o(e_setup), .err_hold_o(e_hold), .err_width_o(e_width)
  );

  always @(posedge clk) if (rst_n && vld) vld_count <= vld_count + 1;

  // {word sent, expected offset-binary}
  localparam logic [31:0] TBL [6] = '{
    {16'h1234, 16'h9234}, {16'h8000, 16'h0000}, {16'h7FFF, 16'hFFFF},
    {16'hFFFF, 16'h7FFF}, {16'h0001, 16'h8001}, {16'hA5C3, 16'h25C3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sample();
    wait_cyc(6);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; bclk = 1'b0; sdata = 1'b0; lat_n = 1'b1;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i];
      wait_cyc(10);
      bclk = 1'b1;
      wait_cyc(10);
      bclk = 1'b0;
    end
  endtask

  task automatic pulse_latch(input int lo);
    wait_cyc(10);
    lat_n = 1'b0;
    wait_cyc(lo);
    lat_n = 1'b1;
    wait_cyc(10);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 word", 32'(word), 32'h0);
    check("R1/R5 offset word", 32'(word_ob), 32'h8000);
    check("R1 flags", {29'h0, e_setup, e_hold, e_width}, 32'h0);
    check("R1 strobe", 32'(vld), 32'h0);

    // R2 R5: walk the vector table
    for (int k = 0; k < 6; k++) begin
      send_bits({16'h0, TBL[k][31:16]}, W);
      pulse_latch(10);
      sample();
      check("R2 word", 32'(word), 32'(TBL[k][31:16]));
      check("R5 offset", 32'(word_ob), 32'(TBL[k][15:0]));
    end
    check("R6 one strobe per latch", 32'(vld_count), 32'd6);
    check("R7/R8/R9 no false flags", {29'h0, e_setup, e_hold, e_width}, 32'h0);

    // R3: bits without a latch leave the word alone
    send_bits(32'h0000_5555, W);
    sample();
    check("R3 unchanged without latch", 32'(word), 32'hA5C3);
    pulse_latch(10);
    sample();
    check("R3 updates on latch", 32'(word), 32'h5555);

    // R4: 20 bits, last 16 kept
    send_bits(32'h0005_ACE7, 20);
    pulse_latch(10);
    sample();
    check("R4 last bits kept", 32'(word), 32'hACE7);
    check("R4/R5 offset", 32'(word_ob), 32'h2CE7);

    // R7: data changes 2 cycles before a rising edge
    do_reset();
    wait_cyc(10);
    sdata = 1'b1;
    wait_cyc(2);
    bclk = 1'b1;
    wait_cyc(10);
    bclk = 1'b0;
    sample();
    check("R7 setup flag", 32'(e_setup), 32'h1);
    check("R7 hold not flagged", 32'(e_hold), 32'h0);
    // R10: clean traffic keeps the flag
    send_bits(32'h0000_1111, W);
    pulse_latch(10);
    sample();
    check("R10 setup flag sticky", 32'(e_setup), 32'h1);

    // R8: data changes 1 cycle after a rising edge
    do_reset();
    wait_cyc(10);
    bclk = 1'b1;
    wait_cyc(1);
    sdata = 1'b1;
    wait_cyc(9);
    bclk = 1'b0;
    sample();
    check("R8 hold flag", 32'(e_hold), 32'h1);
    check("R8 setup not flagged", 32'(e_setup), 32'h0);

    // R9: short latch-enable low time
    do_reset();
    pulse_latch(3);
    sample();
    check("R9 latch width flag", 32'(e_width), 32'h1);

    // R9: short clock high time
    do_reset();
    wait_cyc(10);
    bclk = 1'b1;
    wait_cyc(3);
    bclk = 1'b0;
    sample();
    check("R9 clock high flag", 32'(e_width), 32'h1);
    check("R9 other flags clear", {30'h0, e_setup, e_hold}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule